// File: doc/BRIEF.md
# Programmable serial CRC accumulator

This block folds a serial bit stream into a cyclic redundancy remainder, one bit per clock. Its datapath is a modular (Galois-form) shift register with an XOR gate in front of each stage. A runtime polynomial mask chooses both how many stages take part and which stages receive the feedback term, so one instance can run any check from 1 bit up to the `W`-bit maximum (8 bits by default).

Software, or a controlling state machine, programs the block over a plain register write port. The usual order is: clear the enable bit, write the polynomial mask, write the initial remainder (the seed), then set the enable bit and stream bits in most-significant-first. To fetch the result, clear the enable bit and read `rem_rdata`. Bits arrive on a valid/ready pair. `bit_ready` is high only while the block is enabled and holds a non-zero mask. A bit is consumed on each rising edge where `bit_valid` and `bit_ready` are both high. While `bit_ready` is low the sender keeps `bit_valid` and `bit_data` steady and waits; nothing is lost or buffered.

Mask encoding: the highest set bit, at index L-1, fixes the check length L. Each lower set bit at index k-1 marks a polynomial term x^k (1 <= k < L). The x^0 term is implied. As an example, the 8-bit polynomial x^8+x^2+x+1 is written 0x83.

Top module: `serial_crc`

## Requirements
- R1: After reset, `bit_ready` is 0, `rem_rdata` is 0, the block is disabled and the polynomial mask is 0.
- R2: A write to address 0 sets the enable flag to `reg_wdata[0]`. `bit_ready` is 1 exactly when the enable flag is 1 and the polynomial mask is non-zero.
- R3: A write to address 1 replaces the polynomial mask only while the block is disabled. A mask write made while enabled is ignored, and accumulation keeps using the previous mask.
- R4: A write to address 2 while disabled loads `reg_wdata` straight into the remainder, unmasked, and it is readable on `rem_rdata` after that clock edge. A write to address 2 while enabled has no effect.
- R5: On each accepted bit d, with length L taken from the mask: fb = d XOR rem[L-1]; the new rem[0] = fb; for 1 <= i < L, the new rem[i] = rem[i-1] XOR (fb AND mask[i-1]).
- R6: The remainder does not change on any edge where no bit is accepted and no seed is loaded, including when `bit_valid` is high while `bit_ready` is low.
- R7: While the block is enabled, `rem_rdata` reads 0. While disabled, it shows the remainder.
- R8: After any accepted bit, every remainder bit at index L or above is 0.
- R9: With mask 0x83 and seed 0, feeding the bytes 0x00 to 0xFF MSB-first gives, after each byte, the standard 8-bit CRC of polynomial 0x07 (no reflection, no final XOR).
- R10: A write to address 3 changes neither the enable flag, the mask nor the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the input bit stream is synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 polynomial mask, 2 seed, 3 unused |
| reg_wdata | input | W | Write data |
| bit_valid | input | 1 | Input bit present |
| bit_data | input | 1 | Input bit value |
| bit_ready | output | 1 | Block can take a bit this cycle |
| rem_rdata | output | W | Remainder while disabled, zero while enabled |

## Verification
Every register write and every accepted bit is captured on the rising edge where it is presented. `rem_rdata` and `bit_ready` are combinational views of registers, so each result is due immediately after that one edge. The bench drives inputs at the falling edge and samples at the next falling edge, which is half a cycle after the capturing edge. Because the remainder is visible only while disabled, each step check first writes the enable bit to 0 (one edge), then samples, then re-enables, and the reference model advances only on bits it actually sent.

// File: rtl/scrc_pkg.sv
package scrc_pkg;

  // Register select codes on reg_addr
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_POLY = 2'd1,
    SEL_SEED = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bit of the control word that holds the enable flag
  localparam int unsigned CTRL_EN_BIT = 0;

endpackage

// File: rtl/scrc_cfg.sv
// Control and polynomial registers, plus length decode of the mask.
module scrc_cfg
  import scrc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic         enable,
  output logic [W-1:0] poly,
  output logic [W-1:0] len_sel,
  output logic [W-1:0] len_mask,
  output logic         poly_ok
);

  logic sel_ctrl;
  logic sel_poly;

  assign sel_ctrl = we && (addr == SEL_CTRL);
  assign sel_poly = we && (addr == SEL_POLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      poly   <= '0;
    end else begin
      if (sel_ctrl) begin
        enable <= wdata[CTRL_EN_BIT];
      end
      // mask is frozen while accumulating
      if (sel_poly && !enable) begin
        poly <= wdata;
      end
    end
  end

  // One-hot of the highest set mask bit: the stage whose output feeds back.
  always_comb begin
    len_sel = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (poly[i]) begin
        len_sel    = '0;
        len_sel[i] = 1'b1;
      end
    end
  end

  // Stages at or below the length bit stay live; the rest are cleared.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      acc         = acc | poly[i];
      len_mask[i] = acc;
    end
  end

  assign poly_ok = |poly;

endmodule

// File: rtl/scrc_core.sv
// Modular shift register with a per-stage feedback XOR.
module scrc_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic [W-2:0] taps,
  input  logic [W-1:0] len_sel,
  input  logic [W-1:0] len_mask,
  output logic [W-1:0] rem
);

  logic         fb;
  logic [W-1:0] nxt;

  assign fb = din ^ (|(rem & len_sel));

  generate
    for (genvar i = 0; i < int'(W); i++) begin : g_stage
      if (i == 0) begin : g_head
        assign nxt[i] = fb & len_mask[i];
      end else begin : g_body
        assign nxt[i] = (rem[i-1] ^ (fb & taps[i-1])) & len_mask[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0;
    end else if (load) begin
      rem <= load_data;
    end else if (step) begin
      rem <= nxt;
    end
  end

endmodule

// File: rtl/serial_crc.sv
module serial_crc
  import scrc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         bit_ready,
  output logic [W-1:0] rem_rdata
);

  logic         cfg_enable;
  logic [W-1:0] cfg_poly;
  logic [W-1:0] cfg_len_sel;
  logic [W-1:0] cfg_len_mask;
  logic         cfg_poly_ok;
  logic [W-1:0] core_rem;
  logic         seed_load;
  logic         take_bit;

  scrc_cfg #(.W(W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .enable   (cfg_enable),
    .poly     (cfg_poly),
    .len_sel  (cfg_len_sel),
    .len_mask (cfg_len_mask),
    .poly_ok  (cfg_poly_ok)
  );

  assign bit_ready = cfg_enable && cfg_poly_ok;
  assign take_bit  = bit_valid && bit_ready;
  assign seed_load = reg_we && (reg_addr == SEL_SEED) && !cfg_enable;

  scrc_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (take_bit),
    .din       (bit_data),
    .load      (seed_load),
    .load_data (reg_wdata),
    .taps      (cfg_poly[W-2:0]),
    .len_sel   (cfg_len_sel),
    .len_mask  (cfg_len_mask),
    .rem       (core_rem)
  );

  assign rem_rdata = cfg_enable ? '0 : core_rem;

endmodule

// File: rtl/scrc_checks.sv
module scrc_checks #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         bit_valid,
  input logic         bit_ready,
  input logic [W-1:0] rem_rdata,
  input logic         enable,
  input logic [W-1:0] poly,
  input logic [W-1:0] len_mask,
  input logic [W-1:0] rem
);

  // R7: a ready block is enabled, so its readback is blanked
  p_blank_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> (rem_rdata == '0));

  // R3: the mask cannot move while accumulation is on
  p_poly_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(poly));

  // R4: a seed written while disabled lands in the remainder
  p_seed_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && !enable) |=> (rem == $past(reg_wdata)));

  // R6: no accepted bit and no seed load leaves the remainder alone
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bit_valid && bit_ready) && !(reg_we && reg_addr == 2'd2 && !enable))
      |=> $stable(rem));

  // R8: stages beyond the programmed length are cleared by a step
  p_above_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> ((rem & ~$past(len_mask)) == '0));

  // R2: ready needs a non-zero mask
  p_ready_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> (poly != '0));

endmodule

bind serial_crc scrc_checks #(.W(W)) u_scrc_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .rem_rdata (rem_rdata),
  .enable    (cfg_enable),
  .poly      (cfg_poly),
  .len_mask  (cfg_len_mask),
  .rem       (core_rem)
);

// File: tb/serial_crc_bench.sv
module serial_crc_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [7:0] rem_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_crc #(.W(8)) u_serial_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_ready (bit_ready),
    .rem_rdata (rem_rdata)
  );

  // Generic step from the requirement's rule, in shift-and-mask form
  function automatic logic [7:0] ref_step(logic [7:0] s, logic b, int len, logic [7:0] p);
    logic [7:0] lm;
    logic [7:0] g;
    logic       fb;
    lm = 8'((9'd1 << len) - 9'd1);
    fb = b ^ s[len-1];
    g  = 8'(((p & ~(8'd1 << (len-1))) << 1) | 8'd1) & lm;
    return ((s << 1) & lm) ^ (fb ? g : 8'd0);
  endfunction

  // Textbook bitwise CRC-8, polynomial 0x07
  function automatic logic [7:0] std8(logic [7:0] c, logic b);
    logic [7:0] sh;
    sh = c << 1;
    return (c[7] ^ b) ? (sh ^ 8'h07) : sh;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = b;
    @(posedge clk);
    #1 bit_valid = 1'b0;
  endtask

  task automatic peek(output logic [7:0] v, output logic r);
    @(negedge clk);
    v = rem_rdata; r = bit_ready;
  endtask

  // Disable, read the remainder, optionally re-enable
  task automatic read_rem(output logic [7:0] v, input bit reenable);
    logic r;
    wr(2'd0, 8'h00);
    peek(v, r);
    if (reenable) wr(2'd0, 8'h01);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v0;
    logic       r;
    logic [7:0] s;
    logic [7:0] pats [4];
    pats[0] = 8'h01; pats[1] = 8'h5A; pats[2] = 8'h27; pats[3] = 8'h7F;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(v, r);
    check8("R1 rem_rdata after reset", v, 8'h00);
    check8("R1 bit_ready after reset", {7'd0, r}, 8'h00);

    // R2 enabled with zero mask is not ready
    wr(2'd0, 8'h01);
    peek(v, r);
    check8("R2 ready with zero mask", {7'd0, r}, 8'h00);
    wr(2'd0, 8'h00);

    // R9 standard CRC-8 across all byte values
    wr(2'd1, 8'h83);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    peek(v, r);
    check8("R2 ready with mask and enable", {7'd0, r}, 8'h01);
    s = 8'h00;
    for (int b = 0; b < 256; b++) begin
      for (int k = 7; k >= 0; k--) begin
        logic bb;
        bb = b[k];
        send(bb);
        s = std8(s, bb);
        if ((b % 5) == 0 && k == 4) begin
          repeat (2) @(posedge clk); // R6 gaps with valid low
        end
      end
      if ((b % 64) == 0) begin
        peek(v, r);
        check8("R7 readback blank while enabled", v, 8'h00);
      end
      read_rem(v, 1'b1);
      check8($sformatf("R9 crc after byte %0d", b), v, s);
    end
    wr(2'd0, 8'h00);

    // R5 / R8 / R4 sweep over lengths and tap patterns
    for (int len = 2; len <= 8; len++) begin
      for (int pi = 0; pi < 4; pi++) begin
        logic [7:0] p;
        p = 8'((9'd1 << (len-1)) | (9'(pats[pi]) & ((9'd1 << (len-1)) - 9'd1)));
        wr(2'd1, p);
        wr(2'd2, 8'hFF);
        peek(v, r);
        check8("R4 raw seed readback", v, 8'hFF);
        s = 8'hFF;
        wr(2'd0, 8'h01);
        for (int j = 0; j < 12; j++) begin
          logic bb;
          bb = (((j * 7) + len + pi) % 3) == 0;
          send(bb);
          s = ref_step(s, bb, len, p);
          read_rem(v, 1'b1);
          check8($sformatf("R5 step len=%0d mask=%02h bit %0d", len, p, j), v, s);
          check8("R8 bits above length clear", v >> len, 8'h00);
        end
        wr(2'd0, 8'h00);
      end
    end

    // R3 mask write while enabled is ignored
    wr(2'd1, 8'h83);
    wr(2'd2, 8'h5A);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h09);
    s = 8'h5A;
    for (int j = 0; j < 8; j++) begin
      logic bb;
      bb = j[0] ^ j[2];
      send(bb);
      s = ref_step(s, bb, 8, 8'h83);
    end
    read_rem(v, 1'b1);
    check8("R3 mask kept while enabled", v, s);

    // R4 seed write while enabled is ignored
    wr(2'd2, 8'h11);
    read_rem(v, 1'b0);
    check8("R4 seed ignored while enabled", v, s);

    // R6 valid held high while not ready
    @(negedge clk);
    bit_valid = 1'b1; bit_data = 1'b1;
    repeat (3) @(posedge clk);
    #1 bit_valid = 1'b0;
    peek(v, r);
    check8("R6 remainder held while not ready", v, s);
    check8("R6 ready low while disabled", {7'd0, r}, 8'h00);

    // R10 unused address has no effect
    v0 = v;
    wr(2'd3, 8'hFF);
    peek(v, r);
    check8("R10 remainder after addr 3 write", v, v0);
    check8("R10 enable after addr 3 write", {7'd0, r}, 8'h00);
    wr(2'd0, 8'h01);
    send(1'b0);
    s = ref_step(s, 1'b0, 8, 8'h83);
    read_rem(v, 1'b0);
    check8("R10 mask after addr 3 write", v, s);

    done = 1'b1;
    report();
  end

endmodule